// File: doc/BRIEF.md
# Configuration Chain Forwarder

This block sits on the configuration port of one device in a chain of devices. After a start pulse it takes in the local device's own configuration payload. The payload length is a programmed count: bits in serial modes, bytes in parallel mode. Once the local payload is complete, the block can hand the rest of the incoming stream to the next device. It does this in one of two ways. In bypass, the data passes through a one-bit register to a serial output. In flow-through, the block pulls the next device's chip-select low and lets go of the shared data bus.

The port mode and the chain option are captured on the start pulse. They then stay fixed until the next start. In serial modes, data arrives one bit at a time. In slave serial mode an external strobe marks each bit. In master serial mode the block makes its own periodic strobe. In parallel mode, data arrives one byte at a time with a valid/ready handshake. In parallel bypass, each byte is shifted out least significant bit first. A wake-up pulse, taken only after the local payload is done, ends all forwarding.

Top module: `cfg_chain_fwd`

## Requirements
- R1: After reset and before the first start pulse, every data input is ignored. The outputs stay at cs_next_n_o=1, dout_o=1, dout_stb_o=0, local_done_o=0, par_rdy_o=0, mclk_o=0 and dbus_hold_o=0.
- R2: A start pulse captures port_mode_i (0 slave serial, 1 master serial, 2 slave parallel, 3 treated as slave serial), chain_opt_i (0 off, 1 bypass, 2 flow-through, 3 treated as off) and local_len_i. It clears the unit counter and the wake latch and presets the bypass register to 1, so dout_o=1. It returns cs_next_n_o to 1, except at once-complete zero length with flow-through. Later changes on the mode, option and length inputs have no effect until the next start.
- R3: The block consumes exactly local_len_i units, counting bits in serial modes and bytes in parallel mode. local_done_o rises after the clock edge that consumes the last unit, or right after the start edge when the length is 0. Until it rises, dout_o stays 1 and dout_stb_o stays 0.
- R4: In serial bypass after done, a bit sampled at an edge appears on dout_o just after that edge. dout_stb_o is high for that one cycle. The bit holds while no new bit arrives.
- R5: In parallel bypass after done, bit 0 of an accepted byte appears on dout_o after the accepting edge. Bits 1 to 7 follow, one per clock, and dout_stb_o is high in each of those cycles.
- R6: In parallel mode, par_rdy_o is 1 while the local payload loads. In bypass it falls after an accepting edge and rises again after the seventh shift, giving one byte every 8 cycles. A byte offered while par_rdy_o is 0 is ignored.
- R7: In master serial mode, mclk_o is a one-cycle pulse every MDIV cycles. The first pulse comes MDIV edges after the start edge. ser_din_i is sampled in pulse cycles and ser_vld_i is ignored. In other modes mclk_o stays 0.
- R8: In parallel flow-through, the edge that completes the local payload drives cs_next_n_o to 0 and dbus_hold_o to 0, and par_rdy_o to 0. After that, no data is forwarded on dout_o.
- R9: Flow-through chosen with a serial mode causes no handoff and no forwarding: cs_next_n_o stays 1 and dout_o stays 1.
- R10: With the chain option off, nothing is forwarded after done. In parallel mode, further bytes are taken (par_rdy_o=1) and dropped.
- R11: wake_i is ignored before done. After a wake pulse at done, by the second edge dout_o=1, dout_stb_o=0, par_rdy_o=0, mclk_o=0 and dbus_hold_o=0. cs_next_n_o keeps its value.
- R12: Once bypass forwarding has begun, only a wake pulse, a start pulse or reset ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_i | input | 1 | Start of a configuration; captures mode, option and length |
| port_mode_i | input | 2 | Port mode select |
| chain_opt_i | input | 2 | Chain option select |
| local_len_i | input | LEN_W | Local payload length in units |
| ser_din_i | input | 1 | Serial data bit |
| ser_vld_i | input | 1 | Serial bit strobe in slave serial mode |
| par_d_i | input | BYTE_W | Parallel data byte |
| par_vld_i | input | 1 | Parallel byte valid |
| wake_i | input | 1 | Wake-up sequence complete pulse |
| par_rdy_o | output | 1 | Block can accept a parallel byte |
| dout_o | output | 1 | Forwarded serial data to next device |
| dout_stb_o | output | 1 | A new bit is on dout_o this cycle |
| cs_next_n_o | output | 1 | Active-low chip-select for the next device |
| dbus_hold_o | output | 1 | Block still claims the shared parallel bus |
| mclk_o | output | 1 | Master serial bit strobe |
| local_done_o | output | 1 | Local payload complete |

## Verification
Every result is visible one edge after its cause. This covers local_done_o and the flow-through chip-select, which follow the last consumed unit. It also covers a serial forwarded bit, and bit 0 of a parallel byte, which follow their sampling edge. The remaining seven bits of a byte follow one per edge, and par_rdy_o returns after the seventh of them. The first master strobe is due MDIV edges after start, and the effects of a wake pulse are complete by the second edge. The bench changes inputs at the falling edge and reads outputs at the next falling edge. Each check therefore lands on the exact cycle its requirement names. The bench also keeps its own cycle count to measure the strobe spacing.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  typedef enum logic [1:0] {
    PM_SER_SLV = 2'd0,
    PM_SER_MST = 2'd1,
    PM_PAR_SLV = 2'd2,
    PM_RSVD    = 2'd3
  } port_mode_e;

  typedef enum logic [1:0] {
    CO_OFF    = 2'd0,
    CO_BYPASS = 2'd1,
    CO_FLOW   = 2'd2,
    CO_RSVD   = 2'd3
  } chain_opt_e;

  // decoded selection captured at start of configuration
  typedef struct packed {
    logic par;
    logic master;
    logic bypass;
    logic flow;
  } cfg_sel_t;

  function automatic cfg_sel_t decode_sel(input logic [1:0] pm, input logic [1:0] co);
    cfg_sel_t s;
    s.par    = (pm == PM_PAR_SLV);
    s.master = (pm == PM_SER_MST);
    s.bypass = (co == CO_BYPASS);
    // handoff of the chip-select only makes sense on the byte-wide bus
    s.flow   = (co == CO_FLOW) && (pm == PM_PAR_SLV);
    return s;
  endfunction

endpackage

// File: rtl/cfg_chain_ctrl.sv
module cfg_chain_ctrl
  import cfg_chain_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MDIV  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       port_mode_i,
  input  logic [1:0]       chain_opt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ser_vld_i,
  input  logic             par_vld_i,
  input  logic             wake_i,
  output logic             sel_par_o,
  output logic             sel_off_o,
  output logic             active_o,
  output logic             done_o,
  output logic             wake_o,
  output logic             fwd_o,
  output logic             ser_tick_o,
  output logic             cs_n_o,
  output logic             hold_o,
  output logic             mclk_o
);

  localparam int DIV_W = (MDIV > 1) ? $clog2(MDIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MDIV - 1);

  cfg_sel_t         sel_in, sel_q;
  logic             active_q, done_q, wake_q, fwd_q, cs_n_q, hold_q, mclk_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             ser_tick, take_local, last_unit, wake_hit, zero_len;

  assign sel_in     = decode_sel(port_mode_i, chain_opt_i);
  assign zero_len   = (len_i == '0);
  assign ser_tick   = active_q && !sel_q.par && !wake_q && (sel_q.master ? mclk_q : ser_vld_i);
  assign take_local = active_q && !done_q && (sel_q.par ? par_vld_i : ser_tick);
  assign last_unit  = ((cnt_q + LEN_W'(1)) == len_q);
  assign wake_hit   = active_q && done_q && !wake_q && wake_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sel_q    <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      wake_q   <= 1'b0;
      fwd_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      hold_q   <= 1'b0;
      div_q    <= '0;
      mclk_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sel_q    <= sel_in;
      len_q    <= len_i;
      cnt_q    <= '0;
      done_q   <= zero_len;
      wake_q   <= 1'b0;
      fwd_q    <= zero_len && sel_in.bypass;
      cs_n_q   <= !(zero_len && sel_in.flow);
      hold_q   <= sel_in.par && !(zero_len && sel_in.flow);
      div_q    <= '0;
      mclk_q   <= 1'b0;
    end else if (active_q) begin
      if (take_local) begin
        cnt_q <= cnt_q + LEN_W'(1);
        if (last_unit) begin
          done_q <= 1'b1;
          fwd_q  <= sel_q.bypass;
          if (sel_q.flow) begin
            cs_n_q <= 1'b0;
            hold_q <= 1'b0;
          end
        end
      end
      if (wake_hit) begin
        wake_q <= 1'b1;
        fwd_q  <= 1'b0;
        hold_q <= 1'b0;
      end
      if (sel_q.master && !wake_q) begin
        div_q  <= (div_q == DIV_LAST) ? '0 : div_q + DIV_W'(1);
        mclk_q <= (div_q == DIV_LAST);
      end else begin
        mclk_q <= 1'b0;
      end
    end
  end

  assign sel_par_o  = sel_q.par;
  assign sel_off_o  = !sel_q.bypass && !sel_q.flow;
  assign active_o   = active_q;
  assign done_o     = done_q;
  assign wake_o     = wake_q;
  assign fwd_o      = fwd_q;
  assign ser_tick_o = ser_tick;
  assign cs_n_o     = cs_n_q;
  assign hold_o     = hold_q;
  assign mclk_o     = mclk_q;

  // R8: next device selected only after a completed parallel flow-through load
  a_r8_cs_only_flow: assert property (@(posedge clk) disable iff (rst)
    !cs_n_q |-> (done_q && sel_q.flow));

  // R3: never consume more units than programmed
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len_q);

  // R12: bypass forwarding persists until wake or restart
  a_r12_fwd_hold: assert property (@(posedge clk) disable iff (rst)
    (fwd_q && !start_i && !wake_i) |=> fwd_q);

  // R7: the master strobe is a single-cycle pulse
  a_r7_mclk_single: assert property (@(posedge clk) disable iff (rst)
    ((MDIV > 1) && mclk_q) |=> !mclk_q);

  // R11: wake latch only sets once the local payload is in
  a_r11_wake_after_done: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> done_q);

endmodule

// File: rtl/cfg_chain_bypass.sv
module cfg_chain_bypass #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              par_mode_i,
  input  logic              chain_off_i,
  input  logic              active_i,
  input  logic              done_i,
  input  logic              wake_done_i,
  input  logic              fwd_en_i,
  input  logic              ser_tick_i,
  input  logic              ser_din_i,
  input  logic [BYTE_W-1:0] par_d_i,
  input  logic              par_vld_i,
  output logic              dout_o,
  output logic              stb_o,
  output logic              rdy_o
);

  localparam int LEFT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [LEFT_W-1:0] LEFT_FULL = LEFT_W'(BYTE_W - 1);

  logic              byp_q, stb_q;
  logic [BYTE_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              rdy, accept;

  // ready is a decode of registered state only
  assign rdy = active_i && par_mode_i && !wake_done_i &&
               (!done_i || chain_off_i || (fwd_en_i && (left_q == '0)));
  assign accept = fwd_en_i && par_mode_i && par_vld_i && rdy;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      byp_q  <= 1'b1;
      stb_q  <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
    end else if (!fwd_en_i) begin
      byp_q  <= 1'b1;
      stb_q  <= 1'b0;
      left_q <= '0;
    end else if (par_mode_i) begin
      if (accept) begin
        // bit 0 leaves on the accepting edge, the rest follow
        byp_q  <= par_d_i[0];
        sh_q   <= par_d_i >> 1;
        left_q <= LEFT_FULL;
        stb_q  <= 1'b1;
      end else if (left_q != '0) begin
        byp_q  <= sh_q[0];
        sh_q   <= sh_q >> 1;
        left_q <= left_q - LEFT_W'(1);
        stb_q  <= 1'b1;
      end else begin
        stb_q  <= 1'b0;
      end
    end else begin
      if (ser_tick_i) begin
        byp_q <= ser_din_i;
        stb_q <= 1'b1;
      end else begin
        stb_q <= 1'b0;
      end
    end
  end

  assign dout_o = byp_q;
  assign stb_o  = stb_q;
  assign rdy_o  = rdy;

  // R5: a partly sent byte drains by one bit each clock
  a_r5_shift_count: assert property (@(posedge clk) disable iff (rst)
    ((left_q != '0) && fwd_en_i && !start_i) |=> (left_q == $past(left_q) - LEFT_W'(1)));

  // R5: the strobe accompanies every bit of a byte in flight
  a_r5_stb_busy: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |-> stb_q);

  // R3: no forwarded bit unless forwarding was enabled at its edge
  a_r3_quiet_before_fwd: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> $past(fwd_en_i));

endmodule

// File: rtl/cfg_chain_fwd.sv
module cfg_chain_fwd #(
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 8,
  parameter int MDIV   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start_i,
  input  logic [1:0]        port_mode_i,
  input  logic [1:0]        chain_opt_i,
  input  logic [LEN_W-1:0]  local_len_i,
  input  logic              ser_din_i,
  input  logic              ser_vld_i,
  input  logic [BYTE_W-1:0] par_d_i,
  input  logic              par_vld_i,
  input  logic              wake_i,
  output logic              par_rdy_o,
  output logic              dout_o,
  output logic              dout_stb_o,
  output logic              cs_next_n_o,
  output logic              dbus_hold_o,
  output logic              mclk_o,
  output logic              local_done_o
);

  logic sel_par, sel_off, active, done, wake_done, fwd_en, ser_tick;

  cfg_chain_ctrl #(
    .LEN_W (LEN_W),
    .MDIV  (MDIV)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (cfg_start_i),
    .port_mode_i (port_mode_i),
    .chain_opt_i (chain_opt_i),
    .len_i       (local_len_i),
    .ser_vld_i   (ser_vld_i),
    .par_vld_i   (par_vld_i),
    .wake_i      (wake_i),
    .sel_par_o   (sel_par),
    .sel_off_o   (sel_off),
    .active_o    (active),
    .done_o      (done),
    .wake_o      (wake_done),
    .fwd_o       (fwd_en),
    .ser_tick_o  (ser_tick),
    .cs_n_o      (cs_next_n_o),
    .hold_o      (dbus_hold_o),
    .mclk_o      (mclk_o)
  );

  cfg_chain_bypass #(
    .BYTE_W (BYTE_W)
  ) u_bypass (
    .clk         (clk),
    .rst         (rst),
    .start_i     (cfg_start_i),
    .par_mode_i  (sel_par),
    .chain_off_i (sel_off),
    .active_i    (active),
    .done_i      (done),
    .wake_done_i (wake_done),
    .fwd_en_i    (fwd_en),
    .ser_tick_i  (ser_tick),
    .ser_din_i   (ser_din_i),
    .par_d_i     (par_d_i),
    .par_vld_i   (par_vld_i),
    .dout_o      (dout_o),
    .stb_o       (dout_stb_o),
    .rdy_o       (par_rdy_o)
  );

  assign local_done_o = done;

endmodule

// File: tb/cfg_chain_fwd_bench.sv
module cfg_chain_fwd_bench;

  localparam int LEN_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MDIV   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [1:0]        pm = '0;
  logic [1:0]        co = '0;
  logic [LEN_W-1:0]  len = '0;
  logic              ser_din = 1'b0;
  logic              ser_vld = 1'b0;
  logic [BYTE_W-1:0] par_d = '0;
  logic              par_vld = 1'b0;
  logic              wake = 1'b0;
  logic rdy, dout, dstb, cs_n, hold, mclk, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  cfg_chain_fwd #(.LEN_W(LEN_W), .BYTE_W(BYTE_W), .MDIV(MDIV)) u_cfg_chain_fwd (
    .clk(clk), .rst(rst), .cfg_start_i(start), .port_mode_i(pm), .chain_opt_i(co),
    .local_len_i(len), .ser_din_i(ser_din), .ser_vld_i(ser_vld), .par_d_i(par_d),
    .par_vld_i(par_vld), .wake_i(wake), .par_rdy_o(rdy), .dout_o(dout),
    .dout_stb_o(dstb), .cs_next_n_o(cs_n), .dbus_hold_o(hold), .mclk_o(mclk),
    .local_done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  // expected ready after done in parallel mode while no byte is in flight
  function automatic logic exp_idle_rdy(input logic [1:0] o);
    return (o == 2'd2) ? 1'b0 : 1'b1;
  endfunction

  // expected chip-select once parallel local load is complete
  function automatic logic exp_cs_done(input logic [1:0] o);
    return (o == 2'd2) ? 1'b0 : 1'b1;
  endfunction

  task automatic do_start(input logic [1:0] m, input logic [1:0] o, input int l);
    pm = m; co = o; len = LEN_W'(l); start = 1'b1;
    ser_vld = 1'b0; par_vld = 1'b0; wake = 1'b0;
    step();
    start = 1'b0;
    // scramble captured inputs: they must no longer matter (R2)
    pm = 2'($urandom); co = 2'($urandom); len = LEN_W'($urandom);
  endtask

  task automatic run_serial(input logic [1:0] m, input logic [1:0] o, input int L, input int M);
    bit mst;
    bit v;
    logic b;
    logic last_b;
    int sent;
    int prev;
    mst = (m == 2'd1);
    do_start(m, o, L);
    prev = cyc;
    check("R3", done, (L == 0));
    check("R2", dout, 1);
    check("R2", cs_n, 1);
    sent = 0;
    last_b = 1'b1;
    while (sent < L + M) begin
      if (mst) begin
        v = mclk;
        ser_vld = 1'($urandom);
        if (v) begin
          check("R7", 32'(cyc - prev), MDIV);
          prev = cyc;
        end
      end else begin
        v = (($urandom % 4) != 0);
        ser_vld = v;
        check("R7", mclk, 0);
      end
      b = 1'($urandom);
      ser_din = b;
      step();
      if (v) sent++;
      if (sent <= L) begin
        check("R3", dstb, 0);
        check("R3", dout, 1);
        check("R3", done, (sent == L));
      end else if (o == 2'd1) begin
        if (v) begin
          check("R4", dout, b);
          check("R4", dstb, 1);
          last_b = b;
        end else begin
          check("R4", dstb, 0);
          check("R4", dout, last_b);
        end
      end else if (o == 2'd2) begin
        check("R9", dout, 1);
        check("R9", dstb, 0);
        check("R9", cs_n, 1);
      end else begin
        check("R10", dout, 1);
        check("R10", dstb, 0);
      end
    end
    ser_vld = 1'b0;
    wake = 1'b1;
    step();
    wake = 1'b0;
    step();
    check("R11", dout, 1);
    check("R11", dstb, 0);
    check("R11", mclk, 0);
    for (int k = 0; k < 6; k++) begin
      ser_vld = 1'b1;
      ser_din = 1'($urandom);
      step();
      check("R11", dstb, 0);
      check("R11", dout, 1);
      check("R11", mclk, 0);
    end
    ser_vld = 1'b0;
  endtask

  task automatic send_fwd_byte(input logic [BYTE_W-1:0] byt, input string req);
    check("R6", rdy, 1);
    par_d = byt;
    par_vld = 1'b1;
    step();
    check(req, dout, byt[0]);
    check("R5", dstb, 1);
    check("R6", rdy, 0);
    for (int j = 1; j < BYTE_W; j++) begin
      // offered bytes while not ready must be ignored (R6)
      par_vld = 1'($urandom);
      par_d = BYTE_W'($urandom);
      step();
      check("R5", dout, byt[j]);
      check("R5", dstb, 1);
      check("R6", rdy, (j == BYTE_W - 1));
    end
    par_vld = 1'b0;
  endtask

  task automatic run_par(input logic [1:0] o, input int L, input int nb, input bit early_wake);
    logic [BYTE_W-1:0] byt;
    do_start(2'd2, o, L);
    check("R3", done, (L == 0));
    check("R8", cs_n, !((L == 0) && (o == 2'd2)));
    check("R8", hold, !((L == 0) && (o == 2'd2)));
    for (int i = 0; i < L; i++) begin
      repeat ($urandom % 3) begin
        par_vld = 1'b0;
        step();
        check("R3", done, 0);
        check("R3", dstb, 0);
      end
      check("R6", rdy, 1);
      par_vld = 1'b1;
      par_d = BYTE_W'($urandom);
      wake = early_wake && (i == 0);
      step();
      par_vld = 1'b0;
      wake = 1'b0;
      check("R3", done, (i == L - 1));
      check("R3", dout, 1);
      check("R3", dstb, 0);
      if (i == L - 1) begin
        check("R8", cs_n, exp_cs_done(o));
        check("R8", hold, (o != 2'd2));
        check("R8", rdy, exp_idle_rdy(o));
      end else begin
        check("R8", cs_n, 1);
      end
    end
    for (int k = 0; k < nb; k++) begin
      byt = BYTE_W'($urandom);
      repeat ($urandom % 3) begin
        par_vld = 1'b0;
        step();
        check("R5", dstb, 0);
        check("R6", rdy, exp_idle_rdy(o));
      end
      if (o == 2'd1) begin
        send_fwd_byte(byt, "R5");
      end else begin
        par_d = byt;
        par_vld = 1'b1;
        step();
        par_vld = 1'b0;
        if (o == 2'd2) begin
          check("R8", dout, 1);
          check("R8", dstb, 0);
          check("R8", cs_n, 0);
          check("R8", rdy, 0);
        end else begin
          check("R10", dout, 1);
          check("R10", dstb, 0);
          check("R10", cs_n, 1);
          check("R10", rdy, 1);
        end
      end
    end
    if (o == 2'd1) begin
      repeat (10) begin
        pm = 2'($urandom);
        co = 2'($urandom);
        step();
        check("R12", rdy, 1);
        check("R12", dstb, 0);
      end
      send_fwd_byte(BYTE_W'($urandom), "R12");
    end
    par_vld = 1'b0;
    wake = 1'b1;
    step();
    wake = 1'b0;
    step();
    check("R11", rdy, 0);
    check("R11", hold, 0);
    check("R11", dout, 1);
    check("R11", dstb, 0);
    check("R11", cs_n, exp_cs_done(o));
    par_vld = 1'b1;
    step();
    par_vld = 1'b0;
    check("R11", dstb, 0);
    check("R11", rdy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    check("R1", cs_n, 1);
    check("R1", dout, 1);
    check("R1", dstb, 0);
    check("R1", done, 0);
    check("R1", rdy, 0);
    check("R1", mclk, 0);
    check("R1", hold, 0);
    // inputs before any start are ignored
    for (int k = 0; k < 5; k++) begin
      ser_vld = 1'b1; ser_din = 1'($urandom);
      par_vld = 1'b1; par_d = BYTE_W'($urandom);
      wake = 1'($urandom);
      step();
      check("R1", done, 0);
      check("R1", dstb, 0);
      check("R1", dout, 1);
      check("R1", rdy, 0);
      check("R1", cs_n, 1);
    end
    ser_vld = 1'b0; par_vld = 1'b0; wake = 1'b0;

    run_serial(2'd0, 2'd1, 9, 20);
    run_serial(2'd1, 2'd1, 6, 20);
    run_serial(2'd0, 2'd0, 5, 10);
    run_serial(2'd0, 2'd2, 4, 10);
    run_serial(2'd3, 2'd1, 0, 8);
    run_par(2'd1, 5, 6, 1'b1);
    run_par(2'd2, 4, 4, 1'b0);
    run_par(2'd0, 3, 3, 1'b0);
    run_par(2'd1, 0, 2, 1'b0);
    run_par(2'd2, 0, 2, 1'b0);

    // restart in the middle of a forwarded byte (R2)
    do_start(2'd2, 2'd1, 1);
    par_vld = 1'b1; par_d = BYTE_W'($urandom);
    step();
    par_d = 8'hA5;
    step();
    par_vld = 1'b0;
    repeat (3) step();
    do_start(2'd0, 2'd0, 5);
    check("R2", dout, 1);
    check("R2", dstb, 0);
    check("R2", rdy, 0);
    check("R2", done, 0);
    check("R2", cs_n, 1);
    for (int k = 0; k < 5; k++) begin
      ser_vld = 1'b1; ser_din = 1'($urandom);
      step();
      check("R3", done, (k == 4));
    end
    ser_vld = 1'b0;

    for (int r = 0; r < 6; r++) begin
      run_par(2'($urandom % 3), 1 + int'($urandom % 6), 1 + int'($urandom % 4), 1'($urandom));
      run_serial(2'($urandom % 2), 2'($urandom % 3), int'($urandom % 8), 4 + int'($urandom % 12));
    end

    finish_run();
  end

endmodule